// File: doc/BRIEF.md
# Temperature Window Limit Comparator

This block watches a stream of 8-bit temperature results and reports whether each new result lies above or below a programmable window. Two limit registers, an upper and a lower bound, are loaded from a shared write-data bus by separate strobes. On every end-of-conversion pulse the block compares the new temperature against both bounds as signed two's-complement numbers, at 1 °C per LSB. It then updates an over-limit flag and an under-limit flag.

The flags work in one of two ways, chosen by a level input. In follow mode each conversion overwrites the flags with the latest comparison result, so they clear as soon as the temperature is back inside the window. In hold mode a flag that has been set stays set through later in-window conversions. A pulse that marks a bus read of the configuration register clears both flags in either mode. The surrounding bus slave owns the hold-mode bit and the read pulse, and the converter supplies the temperature and its completion pulse.

Top module: `tmpwin_top`

## Requirements
- R1: After reset both flags are 0, the upper limit reads 0x3C (60 °C) and the lower limit reads 0xF6 (−10 °C).
- R2: A pulse on `hi_wr_i` loads `lim_wdata_i` into the upper limit and a pulse on `lo_wr_i` loads it into the lower limit. The new value shows on the outputs one cycle later, and each limit keeps its value when its own strobe is low.
- R3: On an `eoc_i` cycle the over-limit condition is true when the temperature is strictly greater than the upper limit. The limit used is the value held before that cycle, so a limit written in the same cycle does not take part.
- R4: On an `eoc_i` cycle the under-limit condition is true when the temperature is strictly less than the lower limit, using the lower limit held before that cycle.
- R5: With `latch_en_i` = 0, each `eoc_i` sets each flag to its condition. A flag therefore clears one cycle after a conversion inside the window.
- R6: With `latch_en_i` = 1, an `eoc_i` sets a flag if its condition holds. A set flag stays 1 through later conversions whose condition is false.
- R7: A `cfg_rd_i` pulse with no `eoc_i` in the same cycle clears both flags in the next cycle, in either mode.
- R8: When `cfg_rd_i` and `eoc_i` coincide, each flag takes the new condition only. A flag whose condition still holds is therefore 1 again after the read.
- R9: In a cycle with neither `eoc_i` nor `cfg_rd_i`, both flags keep their value whatever `temp_i` does.
- R10: All comparisons are signed. A temperature of 0x80 (−128 °C) is below any lower limit above it and is never over the upper limit, and 0x7F (127 °C) is never under the lower limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| temp_i | input | 8 | New temperature, two's complement, 1 °C per LSB |
| eoc_i | input | 1 | One-cycle end-of-conversion pulse; `temp_i` is valid with it |
| hi_wr_i | input | 1 | Load upper limit from `lim_wdata_i` |
| lo_wr_i | input | 1 | Load lower limit from `lim_wdata_i` |
| lim_wdata_i | input | 8 | Limit write data, two's complement |
| latch_en_i | input | 1 | 1 = hold mode, 0 = follow mode |
| cfg_rd_i | input | 1 | One-cycle pulse marking a read of the configuration register |
| flag_over_o | output | 1 | Over-limit flag |
| flag_under_o | output | 1 | Under-limit flag |
| lim_hi_o | output | 8 | Current upper limit |
| lim_lo_o | output | 8 | Current lower limit |

## Verification
The properties assume `temp_i` is only meaningful while `eoc_i` is high. They also assume `latch_en_i` is a level sampled in the same cycle as the conversion, so a change in it affects only later conversions. The stimulus follows these assumptions while still pulsing reads, conversions and limit writes in every combination, including all three in one cycle. Temperatures and limits are swept across the sign boundary and set equal to each other to reach the strict-comparison edges.

// File: rtl/tmpwin_pkg.sv
package tmpwin_pkg;
   // index of each flag in the flag vector
   typedef enum int unsigned {
      FLG_OVER  = 0,
      FLG_UNDER = 1
   } flag_idx_e;

   localparam int unsigned NUM_FLAGS = 2;

   // reset values expressed in degrees, converted to a W-bit pattern
   function automatic logic [31:0] deg_to_bits(input int deg);
      return 32'(deg);
   endfunction
endpackage

// File: rtl/tmpwin_limit_reg.sv
module tmpwin_limit_reg #(
   parameter int unsigned W        = 8,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_i,
   input  logic [W-1:0] wdata_i,
   output logic [W-1:0] q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q_o <= RST_VAL;
      else if (wr_i) q_o <= wdata_i;
   end
endmodule

// File: rtl/tmpwin_cmp.sv
module tmpwin_cmp #(
   parameter int unsigned W   = 8,
   parameter bit SIGNED_CMP   = 1'b1
) (
   input  logic [W-1:0] temp_i,
   input  logic [W-1:0] hi_i,
   input  logic [W-1:0] lo_i,
   output logic         over_o,
   output logic         under_o
);
   generate
      if (SIGNED_CMP) begin : g_signed
         always_comb begin
            over_o  = $signed(temp_i) > $signed(hi_i);
            under_o = $signed(temp_i) < $signed(lo_i);
         end
      end else begin : g_unsigned
         always_comb begin
            over_o  = temp_i > hi_i;
            under_o = temp_i < lo_i;
         end
      end
   endgenerate
endmodule

// File: rtl/tmpwin_flag_cell.sv
module tmpwin_flag_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic eoc_i,
   input  logic rd_i,
   input  logic latch_i,
   input  logic cond_i,
   output logic flag_o
);
   logic keep;
   // an old flag survives a conversion only in hold mode and only without a read
   assign keep = latch_i & ~rd_i & flag_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     flag_o <= 1'b0;
      else if (eoc_i) flag_o <= cond_i | keep;
      else if (rd_i)  flag_o <= 1'b0;
   end
endmodule

// File: rtl/tmpwin_top.sv
module tmpwin_top #(
   parameter int unsigned W     = 8,
   parameter int          HI_RST_DEG = 60,
   parameter int          LO_RST_DEG = -10,
   parameter bit          SIGNED_CMP = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [7:0]   temp_i,
   input  logic         eoc_i,
   input  logic         hi_wr_i,
   input  logic         lo_wr_i,
   input  logic [7:0]   lim_wdata_i,
   input  logic         latch_en_i,
   input  logic         cfg_rd_i,
   output logic         flag_over_o,
   output logic         flag_under_o,
   output logic [7:0]   lim_hi_o,
   output logic [7:0]   lim_lo_o
);
   import tmpwin_pkg::*;

   localparam logic [31:0] HI_BITS = deg_to_bits(HI_RST_DEG);
   localparam logic [31:0] LO_BITS = deg_to_bits(LO_RST_DEG);
   localparam logic [W-1:0] HI_RST = HI_BITS[W-1:0];
   localparam logic [W-1:0] LO_RST = LO_BITS[W-1:0];

   generate
      if (W != 8) begin : g_bad_width
         $error("tmpwin_top: port widths fixed at 8, W must be 8");
      end
      if (HI_RST_DEG > 127 || HI_RST_DEG < -128 ||
          LO_RST_DEG > 127 || LO_RST_DEG < -128) begin : g_bad_rst
         $error("tmpwin_top: reset limits out of signed range");
      end
   endgenerate

   logic [W-1:0] hi_q, lo_q;
   logic [NUM_FLAGS-1:0] cond_vec, flag_vec;

   tmpwin_limit_reg #(.W(W), .RST_VAL(HI_RST)) u_hi (
      .clk(clk), .rst_n(rst_n), .wr_i(hi_wr_i), .wdata_i(lim_wdata_i), .q_o(hi_q));

   tmpwin_limit_reg #(.W(W), .RST_VAL(LO_RST)) u_lo (
      .clk(clk), .rst_n(rst_n), .wr_i(lo_wr_i), .wdata_i(lim_wdata_i), .q_o(lo_q));

   tmpwin_cmp #(.W(W), .SIGNED_CMP(SIGNED_CMP)) u_cmp (
      .temp_i(temp_i), .hi_i(hi_q), .lo_i(lo_q),
      .over_o(cond_vec[FLG_OVER]), .under_o(cond_vec[FLG_UNDER]));

   generate
      for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
         tmpwin_flag_cell u_cell (
            .clk(clk), .rst_n(rst_n), .eoc_i(eoc_i), .rd_i(cfg_rd_i),
            .latch_i(latch_en_i), .cond_i(cond_vec[i]), .flag_o(flag_vec[i]));
      end
   endgenerate

   assign flag_over_o  = flag_vec[FLG_OVER];
   assign flag_under_o = flag_vec[FLG_UNDER];
   assign lim_hi_o     = hi_q;
   assign lim_lo_o     = lo_q;
endmodule

// File: rtl/tmpwin_chk.sv
module tmpwin_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [7:0] temp_i,
   input logic       eoc_i,
   input logic       hi_wr_i,
   input logic       lo_wr_i,
   input logic [7:0] lim_wdata_i,
   input logic       latch_en_i,
   input logic       cfg_rd_i,
   input logic       flag_over_o,
   input logic       flag_under_o,
   input logic [7:0] lim_hi_o,
   input logic [7:0] lim_lo_o
);
   // R2
   hi_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hi_wr_i |=> lim_hi_o == $past(lim_wdata_i));
   // R2
   lo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lo_wr_i |=> $stable(lim_lo_o));
   // R3
   over_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eoc_i && $signed(temp_i) > $signed(lim_hi_o)) |=> flag_over_o);
   // R4
   under_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eoc_i && $signed(temp_i) < $signed(lim_lo_o)) |=> flag_under_o);
   // R5
   follow_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eoc_i && !latch_en_i && $signed(temp_i) <= $signed(lim_hi_o)) |=> !flag_over_o);
   // R6
   hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eoc_i && latch_en_i && !cfg_rd_i && flag_under_o) |=> flag_under_o);
   // R7
   read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rd_i && !eoc_i) |=> (!flag_over_o && !flag_under_o));
   // R9
   idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_rd_i && !eoc_i) |=> ($stable(flag_over_o) && $stable(flag_under_o)));
endmodule

bind tmpwin_top tmpwin_chk u_chk (
   .clk(clk), .rst_n(rst_n), .temp_i(temp_i), .eoc_i(eoc_i),
   .hi_wr_i(hi_wr_i), .lo_wr_i(lo_wr_i), .lim_wdata_i(lim_wdata_i),
   .latch_en_i(latch_en_i), .cfg_rd_i(cfg_rd_i),
   .flag_over_o(flag_over_o), .flag_under_o(flag_under_o),
   .lim_hi_o(lim_hi_o), .lim_lo_o(lim_lo_o));

// File: tb/sim_tmpwin_top.sv
`timescale 1ns/1ps
module sim_tmpwin_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] temp = '0, wdata = '0;
   logic       eoc = 0, hi_wr = 0, lo_wr = 0, latch = 0, rd = 0;
   logic       f_over, f_under;
   logic [7:0] l_hi, l_lo;

   int checks = 0, errors = 0;
   bit done = 0;

   // reference state
   int m_hi = 60, m_lo = -10;
   bit m_over = 0, m_under = 0;

   always #5 clk = ~clk;

   tmpwin_top u0 (
      .clk(clk), .rst_n(rst_n), .temp_i(temp), .eoc_i(eoc),
      .hi_wr_i(hi_wr), .lo_wr_i(lo_wr), .lim_wdata_i(wdata),
      .latch_en_i(latch), .cfg_rd_i(rd),
      .flag_over_o(f_over), .flag_under_o(f_under),
      .lim_hi_o(l_hi), .lim_lo_o(l_lo));

   function automatic int sval(input logic [7:0] v);
      return (v >= 8'h80) ? int'(v) - 256 : int'(v);
   endfunction

   task automatic compare(input string tag);
      checks++;
      if (f_over !== m_over || f_under !== m_under ||
          l_hi !== 8'(m_hi) || l_lo !== 8'(m_lo)) begin
         errors++;
         $display("FAIL %s: got over=%0b under=%0b hi=%02h lo=%02h exp over=%0b under=%0b hi=%02h lo=%02h",
                  tag, f_over, f_under, l_hi, l_lo, m_over, m_under, 8'(m_hi), 8'(m_lo));
      end
   endtask

   // one clock: model follows the inputs driven now, then outputs compared at negedge
   task automatic tick(input string tag);
      bit ov, un;
      @(posedge clk);
      if (eoc) begin
         ov = sval(temp) > m_hi;
         un = sval(temp) < m_lo;
         m_over  = ov | (latch & ~rd & m_over);
         m_under = un | (latch & ~rd & m_under);
      end else if (rd) begin
         m_over = 0; m_under = 0;
      end
      if (hi_wr) m_hi = sval(wdata);
      if (lo_wr) m_lo = sval(wdata);
      @(negedge clk);
      compare(tag);
      eoc = 0; rd = 0; hi_wr = 0; lo_wr = 0;
   endtask

   task automatic conv(input logic [7:0] t, input string tag);
      temp = t; eoc = 1; tick(tag);
   endtask

   task automatic set_lim(input bit hi, input logic [7:0] v, input string tag);
      wdata = v; hi_wr = hi; lo_wr = ~hi; tick(tag);
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got hang expected completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      compare("R1 reset");
      rst_n = 1;
      @(negedge clk);
      compare("R1 after release");

      // R3 / R4 / R5 follow mode around default window
      conv(8'd61, "R3 above hi");
      conv(8'd60, "R3 equal hi not over, R5 clears");
      conv(8'hF5, "R4 below lo");
      conv(8'hF6, "R4 equal lo not under, R5 clears");
      conv(8'd20, "R5 inside");

      // R9: temp wiggles, no eoc
      temp = 8'd100; tick("R9 idle temp high");
      conv(8'd100, "R3 set");
      temp = 8'd0; tick("R9 flag kept");
      temp = 8'h80; tick("R9 flag kept 2");

      // R7 read clears in follow mode
      rd = 1; tick("R7 read clears");

      // R2 limit writes
      set_lim(1, 8'd10, "R2 hi write");
      set_lim(0, 8'hEC, "R2 lo write");
      conv(8'd11, "R3 new hi");
      // R3 same-cycle write uses old limit
      temp = 8'd12; eoc = 1; wdata = 8'd50; hi_wr = 1; tick("R3 old limit during write");
      conv(8'd12, "R3 new limit in use");

      // R10 sign extremes
      conv(8'h80, "R10 -128 under");
      conv(8'h7F, "R10 127 over");
      set_lim(0, 8'h80, "R2 lo to -128");
      conv(8'h80, "R10 -128 not under min");
      set_lim(1, 8'h7F, "R2 hi to 127");
      conv(8'h7F, "R10 127 not over max");

      // R6 hold mode
      set_lim(1, 8'd30, "R2 hi 30");
      set_lim(0, 8'd0, "R2 lo 0");
      latch = 1;
      conv(8'd31, "R6 set over");
      conv(8'd15, "R6 held through in-window");
      conv(8'hFF, "R6 under adds");
      conv(8'd15, "R6 both held");
      rd = 1; tick("R7 read clears hold");
      conv(8'd15, "R6 stays clear");
      // R8 read and eoc together
      conv(8'd40, "R6 set again");
      temp = 8'd40; eoc = 1; rd = 1; tick("R8 condition holds, flag stays");
      temp = 8'd10; eoc = 1; rd = 1; tick("R8 condition gone, flag clears");
      conv(8'd40, "R6 set");
      rd = 1; tick("R8 read alone clears");
      conv(8'd40, "R8 set again next conversion");
      latch = 0;
      conv(8'd10, "R5 back to follow clears");

      // mixed traffic, model compared every clock
      for (int i = 0; i < 2000; i++) begin
         temp  = 8'($urandom);
         eoc   = ($urandom % 3) == 0;
         rd    = ($urandom % 5) == 0;
         wdata = 8'($urandom);
         hi_wr = ($urandom % 11) == 0;
         lo_wr = ($urandom % 13) == 0;
         if (($urandom % 40) == 0) latch = ~latch;
         tick("R9 mixed traffic");
      end

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule